// File: doc/BRIEF.md
# Extended Accumulator Add-With-Carry Unit

This block is a clocked datapath slice that holds a 36-bit accumulator, made of a 4-bit extension field on top of a 32-bit word, next to a 16-bit status register. When the execute strobe is high, the block sign-extends the 32-bit source word to 36 bits. It adds that value and the current carry flag to the accumulator. The sum goes back into the accumulator, and the condition flags are recomputed from it. The unit is meant for multi-word addition: a wide sum is built one slice per strobe, and each slice passes its carry on to the next.

The unit never saturates. The mode input that would ask for clamping has no effect on the stored result. Software-visible state can be written directly through two load ports. A load in a cycle takes priority over the execute strobe.

Top module: `xacc_adc_unit`

## Requirements
- R1: On a rising edge with `exec_en` high and neither load asserted, the accumulator becomes (accumulator + sign-extended source + C) modulo 2^36. For example, accumulator 0x0_2000_8000 plus source 0x2000_8000 with C=1 gives 0x0_4001_0001.
- R2: The source word is sign-extended before the addition, so bits 35..32 of the addend equal `src_word[31]`.
- R3: The carry flag C (status bit 0) is added at the least significant bit of the 36-bit sum. With C=0, the example in R1 gives 0x0_4001_0000.
- R4: The stored result is never clamped; the `sat_mode` input has no effect on the accumulator or the flags.
- R5: After an execute, C (bit 0) is 1 exactly when the 36-bit addition carries out of bit 35.
- R6: After an execute, N (bit 3) equals result bit 35, and Z (bit 2) is 1 exactly when all 36 result bits are zero.
- R7: After an execute, V (bit 1) is 1 exactly when the signed 36-bit addition overflows. L (bit 6) is sticky: it is set when V is set and is never cleared by an execute.
- R8: After an execute, E (bit 5) is 1 when result bits 35..31 are not all equal. U (bit 4) is 1 when result bits 31 and 30 are equal.
- R9: An execute leaves status bits 15..7 unchanged. For example, status 0x0301 becomes 0x0300 for the example in R1.
- R10: When `exec_en`, `acc_load_en` and `stat_load_en` are all low, the accumulator and status register hold their values, whatever the source word is.
- R11: `acc_load_en` writes `acc_load_val` and `stat_load_en` writes `stat_load_val` on the rising edge. If either load is high, the execute strobe is ignored in that cycle.
- R12: A synchronous active-high reset clears the accumulator and the whole status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe for the add-with-carry |
| src_word | input | 32 | Source operand, treated as signed |
| sat_mode | input | 1 | Clamp request; has no effect |
| acc_load_en | input | 1 | Write strobe for the accumulator |
| acc_load_val | input | 36 | Value written into the accumulator |
| stat_load_en | input | 1 | Write strobe for the status register |
| stat_load_val | input | 16 | Value written into the status register |
| acc_out | output | 36 | Current accumulator |
| stat_out | output | 16 | Current status register (flags in bits 6..0) |

## Verification
The in-RTL assertions check several rules on every cycle: N and Z agree with the stored accumulator after each execute, L never falls while no load is active, the upper status bits survive an execute, idle cycles change nothing, and reset clears both registers. The exact sum, the carry injection, sign extension, overflow, and the E and U patterns depend on particular operand values. Only the bench's directed scenarios can show those, and it compares them against an independent model of the requirements.

// File: rtl/xacc_pkg.sv
package xacc_pkg;

    parameter int WORD_W = 32;
    parameter int EXT_W  = 4;
    parameter int STAT_W = 16;
    localparam int ACC_W = WORD_W + EXT_W;

    // flag positions inside the status register
    localparam int FP_C = 0;
    localparam int FP_V = 1;
    localparam int FP_Z = 2;
    localparam int FP_N = 3;
    localparam int FP_U = 4;
    localparam int FP_E = 5;
    localparam int FP_L = 6;
    localparam int NUM_FLAGS = 7;

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [STAT_W-1:0] stat_t;

    typedef struct packed {
        logic l;
        logic e;
        logic u;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        acc_t sum;
        logic cout;
        logic ovf;
    } add_res_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_EXEC = 2'd1,
        OP_LOAD = 2'd2
    } op_e;

    function automatic acc_t sign_ext(input word_t w);
        return {{EXT_W{w[WORD_W-1]}}, w};
    endfunction

    function automatic stat_t merge_flags(input stat_t old, input flags_t f);
        stat_t s;
        s       = old;
        s[FP_C] = f.c;
        s[FP_V] = f.v;
        s[FP_Z] = f.z;
        s[FP_N] = f.n;
        s[FP_U] = f.u;
        s[FP_E] = f.e;
        s[FP_L] = f.l;
        return s;
    endfunction

endpackage

// File: rtl/xacc_adder.sv
module xacc_adder
    import xacc_pkg::*;
(
    input  acc_t     acc_in,
    input  word_t    src_in,
    input  logic     cin,
    output add_res_t res
);
    localparam int SUM_W = ACC_W + 1;

    acc_t             addend;
    logic [SUM_W-1:0] wide;

    always_comb begin
        addend   = sign_ext(src_in);
        wide     = {1'b0, acc_in} + {1'b0, addend} + {{ACC_W{1'b0}}, cin};
        res.sum  = wide[ACC_W-1:0];
        res.cout = wide[ACC_W];
        res.ovf  = (acc_in[ACC_W-1] == addend[ACC_W-1]) &&
                   (wide[ACC_W-1] != acc_in[ACC_W-1]);
    end
endmodule

// File: rtl/xacc_flag_gen.sv
module xacc_flag_gen
    import xacc_pkg::*;
(
    input  add_res_t res,
    input  logic     l_prev,
    output flags_t   flags
);
    localparam int EXT_TOP = ACC_W - 1;
    localparam int EXT_BOT = WORD_W - 1;

    logic [EXT_TOP-EXT_BOT:0] ext_bits;

    always_comb begin
        ext_bits = res.sum[EXT_TOP:EXT_BOT];
        flags.c  = res.cout;
        flags.v  = res.ovf;
        flags.z  = (res.sum == '0);
        flags.n  = res.sum[ACC_W-1];
        flags.u  = (res.sum[WORD_W-1] == res.sum[WORD_W-2]);
        flags.e  = !((&ext_bits) || !(|ext_bits));
        flags.l  = l_prev | res.ovf;
    end
endmodule

// File: rtl/xacc_adc_unit.sv
module xacc_adc_unit
    import xacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [WORD_W-1:0] src_word,
    input  logic              sat_mode,
    input  logic              acc_load_en,
    input  logic [ACC_W-1:0]  acc_load_val,
    input  logic              stat_load_en,
    input  logic [STAT_W-1:0] stat_load_val,
    output logic [ACC_W-1:0]  acc_out,
    output logic [STAT_W-1:0] stat_out
);
    acc_t     acc_q;
    stat_t    stat_q;
    add_res_t add_res;
    flags_t   new_flags;
    op_e      op;

    xacc_adder u_adder (
        .acc_in (acc_q),
        .src_in (src_word),
        .cin    (stat_q[FP_C]),
        .res    (add_res)
    );

    xacc_flag_gen u_flags (
        .res    (add_res),
        .l_prev (stat_q[FP_L]),
        .flags  (new_flags)
    );

    always_comb begin
        if (acc_load_en || stat_load_en) op = OP_LOAD;
        else if (exec_en)                op = OP_EXEC;
        else                             op = OP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            stat_q <= '0;
        end else begin
            unique case (op)
                OP_EXEC: begin
                    acc_q  <= add_res.sum;
                    stat_q <= merge_flags(stat_q, new_flags);
                end
                OP_LOAD: begin
                    if (acc_load_en)  acc_q  <= acc_load_val;
                    if (stat_load_en) stat_q <= stat_load_val;
                end
                default: ;
            endcase
        end
    end

    assign acc_out  = acc_q;
    assign stat_out = stat_q;

    // ---------------- assertions ----------------
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && (stat_q == '0)); // R12

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!exec_en && !acc_load_en && !stat_load_en) |=>
            ($stable(acc_q) && $stable(stat_q))); // R10

    AST_N_MATCHES_ACC: assert property (@(posedge clk) disable iff (rst)
        (exec_en && !acc_load_en && !stat_load_en) |=>
            (stat_q[FP_N] == acc_q[ACC_W-1])); // R6

    AST_Z_MATCHES_ACC: assert property (@(posedge clk) disable iff (rst)
        (exec_en && !acc_load_en && !stat_load_en) |=>
            (stat_q[FP_Z] == (acc_q == '0))); // R6

    AST_L_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_q[FP_L] && !stat_load_en) |=> stat_q[FP_L]); // R7

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (exec_en && !acc_load_en && !stat_load_en) |=>
            (stat_q[STAT_W-1:NUM_FLAGS] == $past(stat_q[STAT_W-1:NUM_FLAGS]))); // R9

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (acc_load_en && exec_en) |=> (acc_q == $past(acc_load_val))); // R11

    AST_SAT_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (exec_en && sat_mode && !acc_load_en && !stat_load_en && add_res.ovf) |=>
            (stat_q[FP_V] && (acc_q[ACC_W-1] != $past(acc_q[ACC_W-1])))); // R4
endmodule

// File: tb/xacc_adc_unit_tb_top.sv
module xacc_adc_unit_tb_top;
    import xacc_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              exec_en;
    logic [WORD_W-1:0] src_word;
    logic              sat_mode;
    logic              acc_load_en;
    logic [ACC_W-1:0]  acc_load_val;
    logic              stat_load_en;
    logic [STAT_W-1:0] stat_load_val;
    logic [ACC_W-1:0]  acc_out;
    logic [STAT_W-1:0] stat_out;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    xacc_adc_unit dut_i (
        .clk(clk), .rst(rst), .exec_en(exec_en), .src_word(src_word),
        .sat_mode(sat_mode), .acc_load_en(acc_load_en), .acc_load_val(acc_load_val),
        .stat_load_en(stat_load_en), .stat_load_val(stat_load_val),
        .acc_out(acc_out), .stat_out(stat_out)
    );

    // independent reference derived from the requirements
    logic [ACC_W-1:0]  m_acc;
    logic [STAT_W-1:0] m_stat;

    task automatic model_exec(input logic [WORD_W-1:0] s);
        logic [ACC_W:0]   w;
        logic [ACC_W-1:0] a, x, r;
        logic             v;
        a = m_acc;
        x = {{EXT_W{s[WORD_W-1]}}, s};
        w = {1'b0, a} + {1'b0, x} + (ACC_W+1)'(m_stat[0]);
        r = w[ACC_W-1:0];
        v = (a[ACC_W-1] == x[ACC_W-1]) && (r[ACC_W-1] != a[ACC_W-1]);
        m_stat[0] = w[ACC_W];
        m_stat[1] = v;
        m_stat[2] = (r == 0);
        m_stat[3] = r[ACC_W-1];
        m_stat[4] = (r[31] == r[30]);
        m_stat[5] = !((r[35:31] == 5'h1f) || (r[35:31] == 5'h00));
        m_stat[6] = m_stat[6] | v;
        m_acc = r;
    endtask

    task automatic check(input string req, input logic [ACC_W-1:0] ea,
                         input logic [STAT_W-1:0] es);
        n_checks++;
        if (acc_out !== ea || stat_out !== es) begin
            n_errors++;
            $display("FAIL %s: acc=%h stat=%h expected acc=%h stat=%h",
                     req, acc_out, stat_out, ea, es);
        end
    endtask

    task automatic idle_inputs();
        exec_en = 0; acc_load_en = 0; stat_load_en = 0; sat_mode = 0;
    endtask

    task automatic load_both(input logic [ACC_W-1:0] a, input logic [STAT_W-1:0] s);
        @(negedge clk);
        acc_load_en = 1; acc_load_val = a; stat_load_en = 1; stat_load_val = s;
        @(negedge clk);
        idle_inputs();
        m_acc = a; m_stat = s;
    endtask

    task automatic run_exec(input logic [WORD_W-1:0] s, input logic sat);
        @(negedge clk);
        exec_en = 1; src_word = s; sat_mode = sat;
        @(negedge clk);
        idle_inputs();
        model_exec(s);
    endtask

    task automatic t_reset();
        rst = 1; idle_inputs(); src_word = '0; acc_load_val = '0; stat_load_val = '0;
        repeat (2) @(negedge clk);
        rst = 0;
        m_acc = '0; m_stat = '0;
        check("R12 reset state", 36'h0, 16'h0);
    endtask

    task automatic t_vector();
        load_both(36'h0_2000_8000, 16'h0301);
        run_exec(32'h2000_8000, 0);
        check("R1 R9 worked example", 36'h0_4001_0001, 16'h0300);
        load_both(36'h0_2000_8000, 16'h0300);
        run_exec(32'h2000_8000, 0);
        check("R3 carry-in zero", 36'h0_4001_0000, 16'h0300);
    endtask

    task automatic t_sign_ext();
        load_both(36'h0, 16'h0);
        run_exec(32'h8000_0000, 0);
        check("R2 negative source", 36'hF_8000_0000, 16'h0008);
        load_both(36'h0_0000_0010, 16'h0);
        run_exec(32'hFFFF_FFF0, 0);
        check("R2 R5 R6 minus cancels", m_acc, m_stat);
    endtask

    task automatic t_carry_zero();
        load_both(36'hF_FFFF_FFFF, 16'h0);
        run_exec(32'h0000_0001, 0);
        check("R5 R6 carry out and zero", 36'h0, 16'h0015);
        run_exec(32'h0000_0000, 0);
        check("R3 carry consumed", 36'h0_0000_0001, 16'h0010);
    endtask

    task automatic t_overflow();
        load_both(36'h7_FFFF_FFFF, 16'h0);
        run_exec(32'h0000_0001, 1);
        check("R4 R7 overflow unclamped", 36'h8_0000_0000, 16'h007A);
        run_exec(32'h0000_0000, 1);
        check("R7 L sticky", 36'h8_0000_0000, 16'h0078);
    endtask

    task automatic t_ext_unnorm();
        load_both(36'h0, 16'hA500);
        run_exec(32'h4000_0000, 0);
        check("R8 R9 U clear E clear", 36'h0_4000_0000, 16'hA500);
        run_exec(32'h4000_0000, 0);
        check("R8 E set", 36'h0_8000_0000, 16'hA520);
        run_exec(32'h1234_5678, 0);
        check("R8 model", m_acc, m_stat);
    endtask

    task automatic t_idle_hold();
        load_both(36'h3_1234_5678, 16'h00C1);
        @(negedge clk); src_word = 32'hDEAD_BEEF; sat_mode = 1;
        repeat (3) @(negedge clk);
        check("R10 idle hold", 36'h3_1234_5678, 16'h00C1);
    endtask

    task automatic t_load_priority();
        load_both(36'h0_0000_0005, 16'h0001);
        @(negedge clk);
        exec_en = 1; src_word = 32'h0000_0100; acc_load_en = 1; acc_load_val = 36'h9_8765_4321;
        @(negedge clk);
        idle_inputs();
        check("R11 acc load beats exec", 36'h9_8765_4321, 16'h0001);
        @(negedge clk);
        exec_en = 1; src_word = 32'h0000_0100; stat_load_en = 1; stat_load_val = 16'h0F00;
        @(negedge clk);
        idle_inputs();
        check("R11 stat load beats exec", 36'h9_8765_4321, 16'h0F00);
    endtask

    task automatic t_mid_reset();
        load_both(36'hA_AAAA_AAAA, 16'hFFFF);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R12 reset mid-run", 36'h0, 16'h0);
    endtask

    initial begin
        fork
            begin : body
                t_reset();
                t_vector();
                t_sign_ext();
                t_carry_zero();
                t_overflow();
                t_ext_unnorm();
                t_idle_hold();
                t_load_priority();
                t_mid_reset();
            end
            begin : watchdog
                repeat (5000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: run hung, actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule